// File: doc/BRIEF.md
# SMBus Block-Read Target with Packet Error Code

This block is the target side of an SMBus block read. It watches sampled SCL and SDA lines and pulls SDA low through an open-drain enable. A write transaction whose command byte is below the memory depth is a send-byte or write-byte/word. It loads that value into an internal address pointer, and the block acknowledges and discards any data bytes that follow. A transaction that carries the block-read command 0xFD, then a repeated start and the read address, makes the block return a byte count of 32. Thirty-two bytes from its internal memory follow, read from the pointer onward.

When `pec_en` is high, one more byte follows the data: a CRC-8 packet error code. It covers every byte of the transaction on the bus. The owning logic fills the memory through a simple synchronous write port. The memory is a plain byte array that maps onto block RAM.

Top module: `smb_blkrd_target`

## Requirements
- R1: An address byte whose upper seven bits equal `OWN_ADDR` with bit 0 low is acknowledged. Any other address leaves SDA released for the rest of the transaction, until the next start.
- R2: The command byte 0xFD is acknowledged and arms a read. An address byte with bit 0 high is acknowledged only after a repeated start that follows 0xFD in the same transaction. Otherwise it is not acknowledged.
- R3: A command byte whose value is below `MEM_DEPTH` is acknowledged and becomes the read pointer. Later written bytes in that transaction are acknowledged and discarded, and the memory contents stay unchanged.
- R4: A command byte of `MEM_DEPTH` or above that is not 0xFD is not acknowledged. The block then ignores the bus until the next start, and the pointer keeps its value.
- R5: The first byte sent after the read address is the count 0x20. Every byte the block sends goes out MSB first, one bit per SCL clock.
- R6: The count is followed by 32 bytes, mem[(ptr+k) mod `MEM_DEPTH`] for k = 0..31. The pointer advances by one for each data byte fully shifted out, so a later block read continues where the previous one stopped.
- R7: With `pec_en` high, a 34th byte follows. It is the CRC-8 (polynomial 0x07, initial value 0x00, MSB first) over the write address, the command, the read address, the count and the data bytes. With `pec_en` low, SDA stays released after the 32nd data byte.
- R8: When the master answers a byte with a NACK, the block sends nothing more in that transaction.
- R9: A start seen in the middle of a byte restarts address reception with the bit counter cleared. A stop seen in the middle of a byte returns the block to idle with the pointer unchanged.
- R10: Reset leaves SDA released. The SDA drive changes only in the cycle after a detected SCL falling edge, start or stop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| pec_en | input | 1 | Append the CRC-8 byte after the data |
| fill_we | input | 1 | Memory fill write strobe |
| fill_addr | input | 6 | Memory fill address (`$clog2(MEM_DEPTH)` bits) |
| fill_data | input | 8 | Memory fill data |
| sda_oe | output | 1 | Pull SDA low when high |

## Verification
The bench sends block reads from several start pointers, including one that wraps past the end of the memory. A design with wrong wrap arithmetic would return bytes from the wrong addresses. Consecutive reads, and a read cut short by a master NACK, check that the pointer moves once per shifted byte. An off-by-one increment would shift every later block. The PEC is checked against a bitwise CRC computed over the whole transaction, so a design that restarted the CRC at the repeated start, or left out an address byte, would send a different code. Unknown commands, a foreign address, a read without 0xFD, and starts and stops inside a byte all check that SDA stays released and the pointer keeps its value. A design that acknowledged too eagerly or kept a stale bit count would pull SDA low or read from a moved pointer.

// File: rtl/smb_blkrd_pkg.sv
package smb_blkrd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_CMD,
    ST_RX_ACK,
    ST_WDATA,
    ST_TX,
    ST_TX_ACK
  } bus_st_t;

  localparam logic [7:0] BLOCK_READ_CMD = 8'hFD;

  // one byte through a CRC-8 register, MSB first
  function automatic logic [7:0] crc8_fold(input logic [7:0] seed,
                                           input logic [7:0] din,
                                           input logic [7:0] poly);
    logic [7:0] r;
    r = seed ^ din;
    for (int i = 0; i < 8; i++) begin
      r = r[7] ? ((r << 1) ^ poly) : (r << 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s    = scl_ff[STAGES-1];
  assign sda_s    = sda_ff[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_byte_mem.sv
module smb_byte_mem #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store[waddr] <= wdata;
    end
    rdata <= store[raddr];
  end

endmodule

// File: rtl/smb_crc8.sv
module smb_crc8 #(
  parameter logic [7:0] POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       upd,
  input  logic       restart,
  input  logic [7:0] din,
  output logic [7:0] crc
);

  import smb_blkrd_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc <= 8'h00;
    end else if (upd) begin
      crc <= crc8_fold(restart ? 8'h00 : crc, din, POLY);
    end
  end

endmodule

// File: rtl/smb_blkrd_target.sv
module smb_blkrd_target #(
  parameter logic [6:0] OWN_ADDR    = 7'h34,
  parameter int         MEM_DEPTH   = 64,
  parameter int         BLK_LEN     = 32,
  parameter logic [7:0] CRC_POLY    = 8'h07,
  parameter int         SYNC_STAGES = 2,
  localparam int        AW          = $clog2(MEM_DEPTH),
  localparam int        IDX_W       = $clog2(BLK_LEN + 2)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          pec_en,
  input  logic          fill_we,
  input  logic [AW-1:0] fill_addr,
  input  logic [7:0]    fill_data,
  output logic          sda_oe
);

  import smb_blkrd_pkg::*;

  localparam logic [7:0]       CNT_BYTE = 8'(BLK_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLK_LEN);
  localparam logic [AW-1:0]    TOP_PTR  = AW'(MEM_DEPTH - 1);

  logic             sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  bus_st_t          st;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic             rw;
  logic             armed;
  logic             mack;
  logic [AW-1:0]    ptr;
  logic [IDX_W-1:0] idx;
  logic [7:0]       mem_rdata;
  logic [7:0]       crc_val;
  logic             crc_upd, crc_restart;
  logic [7:0]       crc_din;

  logic addr_hit, is_blk_cmd, is_ptr_cmd, byte_done, tx_is_data;
  logic more_data, pec_next;
  logic [7:0] next_tx;

  smb_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  smb_byte_mem #(.DEPTH(MEM_DEPTH)) i_mem (
    .clk(clk), .we(fill_we), .waddr(fill_addr), .wdata(fill_data),
    .raddr(ptr), .rdata(mem_rdata)
  );

  smb_crc8 #(.POLY(CRC_POLY)) i_crc (
    .clk(clk), .rst(rst), .upd(crc_upd), .restart(crc_restart),
    .din(crc_din), .crc(crc_val)
  );

  always_comb begin
    addr_hit   = (shreg[7:1] == OWN_ADDR);
    is_blk_cmd = (shreg == BLOCK_READ_CMD);
    is_ptr_cmd = (int'(shreg) < MEM_DEPTH);
    byte_done  = scl_fall && (bitcnt == 4'd8);
    tx_is_data = (idx != '0) && (idx <= LAST_IDX);
    more_data  = (idx < LAST_IDX);
    pec_next   = (idx == LAST_IDX) && pec_en;
    next_tx    = more_data ? mem_rdata : crc_val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      bitcnt      <= '0;
      shreg       <= '0;
      sda_oe      <= 1'b0;
      rw          <= 1'b0;
      armed       <= 1'b0;
      mack        <= 1'b0;
      ptr         <= '0;
      idx         <= '0;
      crc_upd     <= 1'b0;
      crc_restart <= 1'b0;
      crc_din     <= '0;
    end else begin
      crc_upd     <= 1'b0;
      crc_restart <= 1'b0;
      if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
        armed  <= 1'b0;
        bitcnt <= '0;
      end else if (start_ev) begin
        st     <= ST_ADDR;
        sda_oe <= 1'b0;
        bitcnt <= '0;
      end else begin
        case (st)
          ST_ADDR, ST_CMD, ST_WDATA: begin
            if (scl_rise && bitcnt != 4'd8) begin
              shreg  <= {shreg[6:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (byte_done) begin
              if (st == ST_ADDR) begin
                if (addr_hit && (!shreg[0] || armed)) begin
                  sda_oe      <= 1'b1;
                  rw          <= shreg[0];
                  st          <= ST_ADDR_ACK;
                  crc_upd     <= 1'b1;
                  crc_restart <= !shreg[0];
                  crc_din     <= shreg;
                  if (!shreg[0]) armed <= 1'b0;
                end else begin
                  st    <= ST_IDLE;
                  armed <= 1'b0;
                end
              end else if (st == ST_CMD) begin
                if (is_blk_cmd) begin
                  armed   <= 1'b1;
                  sda_oe  <= 1'b1;
                  st      <= ST_RX_ACK;
                  crc_upd <= 1'b1;
                  crc_din <= shreg;
                end else if (is_ptr_cmd) begin
                  ptr     <= shreg[AW-1:0];
                  armed   <= 1'b0;
                  sda_oe  <= 1'b1;
                  st      <= ST_RX_ACK;
                  crc_upd <= 1'b1;
                  crc_din <= shreg;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_RX_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                st      <= ST_TX;
                shreg   <= CNT_BYTE;
                sda_oe  <= ~CNT_BYTE[7];
                idx     <= '0;
                armed   <= 1'b0;
                crc_upd <= 1'b1;
                crc_din <= CNT_BYTE;
              end else begin
                st     <= ST_CMD;
                sda_oe <= 1'b0;
              end
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= ST_WDATA;
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe <= 1'b0;
                st     <= ST_TX_ACK;
                if (tx_is_data) begin
                  ptr <= (ptr == TOP_PTR) ? '0 : ptr + 1'b1;
                end
              end else begin
                shreg  <= {shreg[6:0], 1'b0};
                sda_oe <= ~shreg[6];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack && (more_data || pec_next)) begin
                shreg   <= next_tx;
                sda_oe  <= ~next_tx[7];
                idx     <= idx + 1'b1;
                bitcnt  <= '0;
                st      <= ST_TX;
                crc_upd <= more_data;
                crc_din <= next_tx;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: begin
            sda_oe <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/smb_blkrd_chk.sv
module smb_blkrd_chk
  import smb_blkrd_pkg::*;
#(
  parameter int BLK_LEN = 32,
  parameter int IDX_W   = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             scl_fall,
  input logic             start_ev,
  input logic             stop_ev,
  input logic             sda_oe,
  input logic             pec_en,
  input bus_st_t          st,
  input logic [3:0]       bitcnt,
  input logic [IDX_W-1:0] idx
);

  // R10: drive only moves after a detected SCL fall, start or stop
  assert_oe_after_fall_R10: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> ($past(scl_fall) || $past(start_ev) || $past(stop_ev)));

  // R9: a stop forces idle with SDA released
  assert_stop_idles_R9: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> (st == ST_IDLE && !sda_oe));

  // R9: a start restarts address reception from bit zero
  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> (st == ST_ADDR && bitcnt == 4'd0 && !sda_oe));

  // R1, R4: idle never pulls the line
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !sda_oe);

  // R7: a byte beyond the data block only goes out with the error code enabled
  assert_pec_only_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    (st == ST_TX && int'(idx) > BLK_LEN) |-> pec_en);

endmodule

bind smb_blkrd_target smb_blkrd_chk #(.BLK_LEN(BLK_LEN), .IDX_W(IDX_W)) i_chk (
  .clk(clk), .rst(rst), .scl_fall(scl_fall), .start_ev(start_ev),
  .stop_ev(stop_ev), .sda_oe(sda_oe), .pec_en(pec_en), .st(st),
  .bitcnt(bitcnt), .idx(idx)
);

// File: tb/test_smb_blkrd_target.sv
`timescale 1ns/1ps
module test_smb_blkrd_target;

  localparam int         MEM_DEPTH = 64;
  localparam int         BLK_LEN   = 32;
  localparam logic [6:0] ADDR      = 7'h34;
  localparam int         Q         = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       pec_en = 1'b0;
  logic       fill_we = 1'b0;
  logic [5:0] fill_addr = '0;
  logic [7:0] fill_data = '0;
  logic       sda_oe;
  logic       sda_line;
  int         errors = 0;
  int         checks = 0;
  bit         done = 1'b0;

  assign sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  smb_blkrd_target #(.OWN_ADDR(ADDR), .MEM_DEPTH(MEM_DEPTH), .BLK_LEN(BLK_LEN)) i_smb_blkrd_target (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .pec_en(pec_en),
    .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .sda_oe(sda_oe)
  );

  function automatic logic [7:0] mval(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q / 2); b = sda_line; wq(Q / 2);
    scl = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] v, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(b);
    ack = !b;
  endtask

  task automatic get_byte(output logic [7:0] v, input bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(!ack);
  endtask

  task automatic set_ptr(input logic [7:0] p);
    bit ack;
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    chk(ack, "R1 address ack", ack, 1);
    put_byte(p, ack);
    chk(ack, "R3 pointer command ack", ack, 1);
    bus_stop();
  endtask

  task automatic block_read(input int sp, input bit use_pec, input string tag);
    bit ack;
    logic [7:0] b;
    logic [7:0] crc;
    crc = 8'h00;
    pec_en = use_pec;
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    chk(ack, "R1 write address ack", ack, 1);
    crc = crc_step(crc, {ADDR, 1'b0});
    put_byte(8'hFD, ack);
    chk(ack, "R2 block read command ack", ack, 1);
    crc = crc_step(crc, 8'hFD);
    bus_start();
    put_byte({ADDR, 1'b1}, ack);
    chk(ack, "R2 read address ack", ack, 1);
    crc = crc_step(crc, {ADDR, 1'b1});
    get_byte(b, 1'b1);
    chk(b == 8'h20, "R5 count byte", b, 8'h20);
    crc = crc_step(crc, b);
    for (int k = 0; k < BLK_LEN; k++) begin
      get_byte(b, 1'b1);
      chk(b == mval((sp + k) % MEM_DEPTH), {"R6 data ", tag}, b, mval((sp + k) % MEM_DEPTH));
      crc = crc_step(crc, b);
    end
    if (use_pec) begin
      get_byte(b, 1'b0);
      chk(b == crc, "R7 error code byte", b, crc);
    end else begin
      get_byte(b, 1'b0);
      chk(b == 8'hFF, "R7 released after data", b, 8'hFF);
    end
    bus_stop();
  endtask

  initial begin
    bit ack;
    logic [7:0] b;
    wq(5);
    for (int a = 0; a < MEM_DEPTH; a++) begin
      fill_we = 1'b1; fill_addr = 6'(a); fill_data = mval(a); wq(1);
    end
    fill_we = 1'b0;
    wq(3);
    chk(sda_oe == 1'b0, "R10 reset releases SDA", sda_oe, 0);
    rst = 1'b0;
    wq(5);
    chk(sda_oe == 1'b0, "R10 idle after reset", sda_oe, 0);

    // plain block read, then one that continues from the moved pointer
    set_ptr(8'd5);
    block_read(5, 1'b0, "first");
    block_read(37, 1'b1, "R6 continue");
    // wrap over the end of memory
    set_ptr(8'd50);
    block_read(50, 1'b1, "wrap");

    // R1: foreign address leaves the line free
    bus_start();
    put_byte({7'h35, 1'b0}, ack);
    chk(!ack, "R1 foreign address nack", ack, 0);
    get_byte(b, 1'b0);
    chk(b == 8'hFF, "R1 line released", b, 8'hFF);
    bus_stop();

    // R4: unknown commands
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    put_byte(8'h80, ack);
    chk(!ack, "R4 command 0x80 nack", ack, 0);
    put_byte(8'h00, ack);
    chk(!ack, "R4 ignored until start", ack, 0);
    bus_stop();
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    put_byte(8'hFE, ack);
    chk(!ack, "R4 command 0xFE nack", ack, 0);
    bus_stop();
    block_read(18, 1'b1, "R4 pointer kept");

    // R2: read address without the block read command
    bus_start();
    put_byte({ADDR, 1'b1}, ack);
    chk(!ack, "R2 bare read nack", ack, 0);
    bus_stop();
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    put_byte(8'd3, ack);
    bus_start();
    put_byte({ADDR, 1'b1}, ack);
    chk(!ack, "R2 read after pointer command nack", ack, 0);
    bus_stop();

    // R3: write byte/word data acked and discarded
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    put_byte(8'd10, ack);
    chk(ack, "R3 pointer command ack", ack, 1);
    put_byte(8'h55, ack);
    chk(ack, "R3 data byte ack", ack, 1);
    put_byte(8'hAA, ack);
    chk(ack, "R3 second data byte ack", ack, 1);
    bus_stop();
    block_read(10, 1'b1, "R3 memory unchanged");

    // R8: master ends early after three data bytes
    pec_en = 1'b1;
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    put_byte(8'hFD, ack);
    bus_start();
    put_byte({ADDR, 1'b1}, ack);
    get_byte(b, 1'b1);
    for (int k = 0; k < 3; k++) begin
      get_byte(b, k < 2);
      chk(b == mval(42 + k), "R8 data before nack", b, mval(42 + k));
    end
    get_byte(b, 1'b0);
    chk(b == 8'hFF, "R8 nothing after nack", b, 8'hFF);
    bus_stop();
    block_read(45, 1'b0, "R8 pointer after early end");

    // R9: start inside a byte
    bus_start();
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    chk(ack, "R9 address after mid-byte start", ack, 1);
    put_byte(8'd3, ack);
    chk(ack, "R9 command after mid-byte start", ack, 1);
    bus_stop();
    block_read(3, 1'b1, "R9 after start abort");

    // R9: stop inside the command byte keeps the pointer
    bus_start();
    put_byte({ADDR, 1'b0}, ack);
    put_bit(1'b0); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    chk(sda_oe == 1'b0, "R9 released after mid-byte stop", sda_oe, 0);
    block_read(35, 1'b0, "R9 after stop abort");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule